// File: doc/BRIEF.md
# Fast-Clock to Slow-Oscillator Ratio Meter

This block measures a fast reference clock against a slow low-power oscillator of nominally 32768 Hz. It counts fast-clock cycles across a window of four slow-oscillator periods and keeps the result in a readable field. The fast clock is the block's only clock. Each slow-oscillator rising edge passes through a synchronizer and an edge detector. The window opens on one detected edge and closes on the fourth detected edge after it. At the close, the count is latched into the readable field. The edge that closes one window also opens the next, so the count refreshes for as long as the meter is enabled. With a 20 MHz fast clock the field reads about 2441.

Software sets the enable bit of the ratio register and waits for a small multiple of the slow period, which is well under 1 ms. It then reads the count. The count is trusted only when the oscillator-present flag in the status register is set. Clearing the enable bit stops and clears all of the measurement state, which saves power.

Top module: `lpo_ratio_meter`

## Requirements
- R1: After reset, the ratio register (`reg_addr`=0) reads all zero and the meter is disabled.
- R2: A write to `reg_addr`=0 copies `wr_data[31]` into the enable bit. The enable bit reads back in `rd_data[31]` of the ratio register.
- R3: `rd_data[30:13]` of the ratio register always reads zero. Write data in those bits has no effect.
- R4: `rd_data[12:0]` holds the number of fast-clock cycles between a synchronized slow rising edge and the fourth synchronized slow rising edge after it. For a slow period of exactly P fast cycles, the field reads 4*P.
- R5: While the meter is enabled, it measures windows back to back. A change in the slow period shows up in the field after later windows, with no re-enable.
- R6: A window longer than 8191 fast cycles makes the field read 8191. The count does not wrap.
- R7: When the enable bit is 0, the count field reads zero. Re-enabling starts a fresh measurement that reads zero until its first window completes.
- R8: Between window ends, the count field holds its value.
- R9: The status register (`reg_addr`=1) returns `lpo_present` in bit 8 and zero in every other bit. Writes to `reg_addr`=1 change nothing in the ratio register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; all logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow low-power oscillator, asynchronous to clk |
| lpo_present | input | 1 | External slow oscillator present flag |
| reg_addr | input | 1 | Register select: 0 ratio, 1 status |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |

## Verification
Several slow periods are measured, each with its exact expected count of 4*P. A design that counted one window too few or too many edges, or that was off by one cycle at the window boundary, would miss these exact values. A window longer than the field can hold must pin the count at 8191; a design with a plain counter would wrap to a small number. The bench disables the meter and then re-enables it, and expects zero both while disabled and before the first new window completes. A design that kept stale state would show an old count. The bench also changes the slow period mid-run without re-enabling, to catch a meter that latches only once. It writes all ones and checks that bits 30:13 read zero. It checks that writes to the status register leave the enable bit unchanged.

// File: rtl/lpo_ratio_meter.sv
module lpo_ratio_meter #(
  parameter int CNT_W       = 13,
  parameter int WIN_EDGES   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32,
  parameter int EN_BIT      = 31,
  parameter int STAT_BIT    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              lpo_present,
  input  logic              reg_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int EDGE_W = (WIN_EDGES > 2) ? $clog2(WIN_EDGES) : 1;
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(WIN_EDGES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;
  logic                   en_q;
  logic                   open_q;
  logic [EDGE_W-1:0]      edge_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       latch_q;
  logic [CNT_W-1:0]       cnt_nxt;
  logic                   unused_wr;

  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], slow_clk};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise    = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign cnt_nxt = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      open_q  <= 1'b0;
      edge_q  <= '0;
      cnt_q   <= '0;
      latch_q <= '0;
    end else begin
      if (wr_en && !reg_addr) en_q <= wr_data[EN_BIT];
      if (!en_q) begin
        open_q  <= 1'b0;
        edge_q  <= '0;
        cnt_q   <= '0;
        latch_q <= '0;
      end else if (!open_q) begin
        if (rise) begin
          open_q <= 1'b1;
          edge_q <= '0;
          cnt_q  <= '0;
        end
      end else if (rise && edge_q == EDGE_LAST) begin
        latch_q <= cnt_nxt;
        cnt_q   <= '0;
        edge_q  <= '0;
      end else begin
        cnt_q <= cnt_nxt;
        if (rise) edge_q <= edge_q + 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (!reg_addr) begin
      rd_data[CNT_W-1:0] = latch_q;
      rd_data[EN_BIT]    = en_q;
    end else begin
      rd_data[STAT_BIT]  = lpo_present;
    end
  end
endmodule

module lpo_ratio_meter_chk #(
  parameter int CNT_W    = 13,
  parameter int EDGE_W   = 2,
  parameter int DATA_W   = 32,
  parameter int EN_BIT   = 31,
  parameter int STAT_BIT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              lpo_present,
  input logic              en_q,
  input logic              open_q,
  input logic              rise,
  input logic [EDGE_W-1:0] edge_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  latch_q
);
  localparam logic [CNT_W-1:0]  CMAX  = {CNT_W{1'b1}};
  localparam logic [EDGE_W-1:0] ELAST = {EDGE_W{1'b1}};

  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_addr) |=> (en_q == $past(wr_data[EN_BIT])));

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> (rd_data[EN_BIT-1:CNT_W] == '0));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && open_q && cnt_q == CMAX && !rise) |=> (cnt_q == CMAX));

  a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (latch_q == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !(open_q && rise && edge_q == ELAST)) |=> $stable(latch_q));

  a_r9_status: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr |-> (rd_data[STAT_BIT] == lpo_present && $countones(rd_data) == 32'(lpo_present)));
endmodule

bind lpo_ratio_meter lpo_ratio_meter_chk #(
  .CNT_W(CNT_W), .EDGE_W(EDGE_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT), .STAT_BIT(STAT_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .lpo_present(lpo_present), .en_q(en_q), .open_q(open_q),
  .rise(rise), .edge_q(edge_q), .cnt_q(cnt_q), .latch_q(latch_q)
);

// File: tb/lpo_ratio_meter_tb.sv
module lpo_ratio_meter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        lpo_present = 1'b0;
  logic        reg_addr = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int half   = 4;
  int gcnt   = 0;
  int cycles = 0;
  bit done   = 1'b0;

  localparam int NVEC = 5;
  localparam int VEC_P   [NVEC] = '{8, 20, 62, 100, 610};
  localparam int VEC_EXP [NVEC] = '{32, 80, 248, 400, 2440};

  lpo_ratio_meter dut_i (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .lpo_present(lpo_present),
    .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (gcnt >= half - 1) begin
      gcnt = 0;
      slow_clk = ~slow_clk;
    end else begin
      gcnt = gcnt + 1;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = rd_data;
  endtask

  initial begin
    logic [31:0] v, v2;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    rd(1'b0, v); check("R1 reset ratio word", v, 32'h0);
    rd(1'b1, v); check("R9 status lpo absent", v, 32'h0);
    lpo_present = 1'b1;
    rd(1'b1, v); check("R9 status lpo present", v, 32'h0000_0100);

    for (int i = 0; i < NVEC; i++) begin
      wr(1'b0, 32'h0);
      half = VEC_P[i] / 2;
      wr(1'b0, 32'h8000_0000);
      wait_cyc(6 * VEC_P[i] + 20);
      rd(1'b0, v);
      check($sformatf("R4 count P=%0d", VEC_P[i]), v, 32'h8000_0000 | VEC_EXP[i]);
    end

    wait_cyc(100);
    rd(1'b0, v2);
    check("R8 count held", v2, v);

    wr(1'b1, 32'h0);
    rd(1'b0, v); check("R9 status write ignored", v, 32'h8000_0000 | 2440);

    wr(1'b0, 32'h0);
    rd(1'b0, v); check("R7 disabled reads zero", v, 32'h0);
    rd(1'b0, v); check("R2 enable bit cleared", {31'h0, v[31]}, 32'h0);

    half = 50;
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); check("R3 reserved bits zero", v, 32'h8000_0000);
    wait_cyc(200);
    rd(1'b0, v); check("R7 fresh start reads zero", v, 32'h8000_0000);
    wait_cyc(450);
    rd(1'b0, v); check("R4 count after restart", v, 32'h8000_0000 | 400);

    half = 20;
    wait_cyc(600);
    rd(1'b0, v); check("R5 continuous update", v, 32'h8000_0000 | 160);

    wr(1'b0, 32'h0);
    half = 1050;
    wr(1'b0, 32'h8000_0000);
    wait_cyc(6 * 2100 + 20);
    rd(1'b0, v); check("R6 saturates at 8191", v, 32'h8000_1FFF);

    wr(1'b0, 32'h0);
    rd(1'b0, v); check("R7 off after saturation", v, 32'h0);

    summary();
  end
endmodule